// File: doc/BRIEF.md
# Serial Codec Register Write Engine

This block writes control registers in up to two audio codecs over a three-wire serial link made of a clock, a data line and one active-low select per codec. A host supplies a codec index, a 5-bit register number and a data byte, then pulses a start strobe. The engine pulls down the select of that codec only and shifts out a 16-bit command word, most significant bit first. It then releases the select and raises a one-cycle completion pulse.

Two built-in sequences write every codec in turn, codec 0 first. The speed sequence turns a sample rate in hertz into the codec's speed-mode nibble and writes it to register 0x02. The mute sequence sets or clears the soft-mute bit in register 0x03. The engine has no readback path, so it keeps a shadow copy of registers 0x02 and 0x03 for each codec and does each read-modify-write against that copy. The shadow also follows any direct write to those two registers.

The controller has four states. IDLE accepts a request. DIRECT waits for a single host frame. SEQ_ISSUE loads the next codec's frame. SEQ_WAIT waits for that frame and then goes to the next codec or back to IDLE.

The shifter has six states. SH_IDLE leaves every line high. SH_SELECT holds the select low before the first bit. For each bit, SH_CLK_LOW drives the clock low, SH_DATA presents the bit with the clock still low, and SH_CLK_HIGH raises the clock. SH_HOLD keeps the select low for one more phase after the last bit. Every shifter state except SH_IDLE lasts CLK_DIV cycles.

Top module: `codec_ctrl_wr`

## Requirements
- R1: A frame is 16 bits, sent MSB first. Bits [15:14] hold the device address 2'b10, bit 13 is always 1, bits [12:8] hold the register number and bits [7:0] hold the data byte.
- R2: The data line changes only while the serial clock is low. It is stable while the clock is high with a select asserted, so the codec samples it on the rising clock edge.
- R3: During a transfer, only the select of the addressed codec is low: cs_n[0] for codec 0 and cs_n[1] for codec 1. It stays low for the whole frame.
- R4: After reset and whenever busy is low, sclk, sdo and both cs_n lines are high and done is low.
- R5: busy rises the cycle after a request is accepted. done pulses for exactly one cycle after the last frame of the request, in a cycle when every select is already high. busy falls in the following cycle.
- R6: A start, rate_start or mute_start pulse that arrives while busy is high is ignored and produces no frame.
- R7: A speed sequence writes register 0x02 of codec 0 and then of codec 1. Bits [3:0] become 4'b1010 for a rate above 108000 Hz, 4'b0101 for a rate above 54000 Hz, and 4'b0000 otherwise. Bits [7:4] keep their shadow value.
- R8: A rate_start with a rate of zero starts no frame, and busy stays low.
- R9: A mute sequence writes register 0x03 of codec 0 and then of codec 1. Bit 7 is set to mute_on and bits [6:0] keep their shadow value.
- R10: A direct write to register 0x02 or 0x03 updates that codec's shadow copy. Both shadow copies reset to 0x00.
- R11: Each clock phase lasts CLK_DIV cycles, so a select stays low for exactly 50*CLK_DIV cycles per frame.
- R12: When requests arrive together in the idle state, start has priority over rate_start, and rate_start has priority over mute_start. The requests that lose are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a direct register write |
| chip_idx | input | 1 | Codec addressed by a direct write |
| reg_addr | input | 5 | Register number for a direct write |
| wr_data | input | 8 | Data byte for a direct write |
| rate_start | input | 1 | Request a speed-mode sequence |
| rate_hz | input | 18 | Sample rate in hertz; 0 means unknown |
| mute_start | input | 1 | Request a soft-mute sequence |
| mute_on | input | 1 | Soft-mute value to write |
| sclk | output | 1 | Serial clock; idles high |
| sdo | output | 1 | Serial data; idles high |
| cs_n | output | 2 | Active-low select for each codec |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when a request completes |

## Verification
The assertions assume that request strobes are single-cycle pulses. They also assume that chip_idx, reg_addr, wr_data, rate_hz and mute_on are stable in the cycle a strobe is sampled, and that chip_idx never names a codec that does not exist. The bench drives every input on the falling clock edge, raises each strobe for exactly one cycle, and uses only codec indices 0 and 1. It raises strobes during busy periods on purpose, to show that they are ignored, and never relies on anything but the ports to see the effect.

// File: rtl/codec_wr_pkg.sv
package codec_wr_pkg;

    localparam logic [4:0] SPEED_REG = 5'h02;
    localparam logic [4:0] MUTE_REG  = 5'h03;
    localparam int         MUTE_BIT  = 7;

    typedef enum logic [1:0] {
        T_IDLE,
        T_DIRECT,
        T_SEQ_ISSUE,
        T_SEQ_WAIT
    } ctrl_state_t;

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_SELECT,
        SH_CLK_LOW,
        SH_DATA,
        SH_CLK_HIGH,
        SH_HOLD
    } shift_state_t;

    typedef enum logic {
        OP_SPEED,
        OP_MUTE
    } seq_op_t;

    // Map a sample rate to the 4-bit speed-mode value
    function automatic logic [3:0] speed_mode(input logic [31:0] rate,
                                              input logic [31:0] high_above,
                                              input logic [31:0] mid_above);
        if (rate > high_above)
            return 4'b1010;
        else if (rate > mid_above)
            return 4'b0101;
        else
            return 4'b0000;
    endfunction

endpackage

// File: rtl/codec_frame_shifter.sv
module codec_frame_shifter
    import codec_wr_pkg::*;
#(
    parameter int NCHIP   = 2,
    parameter int CLK_DIV = 4,
    parameter int FRAME_W = 16,
    localparam int CW     = (NCHIP > 1) ? $clog2(NCHIP) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [CW-1:0]      chip,
    input  logic [FRAME_W-1:0] frame,
    output logic               sclk,
    output logic               sdo,
    output logic [NCHIP-1:0]   cs_n,
    output logic               fdone
);

    localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int BIT_W = $clog2(FRAME_W);

    shift_state_t       state, state_nx;
    logic [CNT_W-1:0]   cnt;
    logic [BIT_W-1:0]   bit_idx;
    logic [FRAME_W-1:0] shreg;
    logic [CW-1:0]      chip_q;
    logic               sdo_q;
    logic               fdone_q;
    logic               phase_end;
    logic               last_bit;

    assign phase_end = (cnt == CNT_W'(CLK_DIV - 1));
    assign last_bit  = (bit_idx == BIT_W'(FRAME_W - 1));

    always_comb begin
        state_nx = state;
        unique case (state)
            SH_IDLE:     if (go) state_nx = SH_SELECT;
            SH_SELECT:   if (phase_end) state_nx = SH_CLK_LOW;
            SH_CLK_LOW:  if (phase_end) state_nx = SH_DATA;
            SH_DATA:     if (phase_end) state_nx = SH_CLK_HIGH;
            SH_CLK_HIGH: if (phase_end) state_nx = last_bit ? SH_HOLD : SH_CLK_LOW;
            SH_HOLD:     if (phase_end) state_nx = SH_IDLE;
            default:     state_nx = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= SH_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            chip_q  <= '0;
            sdo_q   <= 1'b1;
            fdone_q <= 1'b0;
        end else begin
            state   <= state_nx;
            fdone_q <= 1'b0;
            if (state == SH_IDLE) begin
                cnt <= '0;
                if (go) begin
                    shreg   <= frame;
                    chip_q  <= chip;
                    bit_idx <= '0;
                end
            end else begin
                cnt <= phase_end ? '0 : cnt + 1'b1;
                if (phase_end) begin
                    case (state)
                        SH_CLK_LOW:  sdo_q <= shreg[FRAME_W-1];
                        SH_CLK_HIGH: begin
                            shreg   <= shreg << 1;
                            bit_idx <= bit_idx + 1'b1;
                        end
                        SH_HOLD: begin
                            sdo_q   <= 1'b1;
                            fdone_q <= 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // Outputs decoded from the registered state
    always_comb begin
        sclk  = !((state == SH_CLK_LOW) || (state == SH_DATA));
        sdo   = sdo_q;
        fdone = fdone_q;
    end

    for (genvar g = 0; g < NCHIP; g++) begin : g_sel
        assign cs_n[g] = !((state != SH_IDLE) && (chip_q == CW'(g)));
    end

    a_r2_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk) && !(&cs_n) && !(&$past(cs_n))) |-> $stable(sdo));

    a_r3_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);

    a_r3_select_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&cs_n) && !(&$past(cs_n))) |-> (cs_n == $past(cs_n)));

    a_r5_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        fdone |-> (&cs_n && sclk && sdo));

endmodule

// File: rtl/codec_shadow_regs.sv
module codec_shadow_regs
    import codec_wr_pkg::*;
#(
    parameter int NCHIP = 2,
    localparam int CW   = (NCHIP > 1) ? $clog2(NCHIP) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [CW-1:0] wchip,
    input  logic [4:0]    waddr,
    input  logic [7:0]    wdata,
    input  logic [CW-1:0] rchip,
    output logic [7:0]    rd_speed,
    output logic [7:0]    rd_mute
);

    logic [7:0] speed_mem [NCHIP];
    logic [7:0] mute_mem  [NCHIP];

    for (genvar g = 0; g < NCHIP; g++) begin : g_chip
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                speed_mem[g] <= 8'h00;
                mute_mem[g]  <= 8'h00;
            end else if (we && (wchip == CW'(g))) begin
                if (waddr == SPEED_REG) speed_mem[g] <= wdata;
                if (waddr == MUTE_REG)  mute_mem[g]  <= wdata;
            end
        end
    end

    assign rd_speed = speed_mem[rchip];
    assign rd_mute  = mute_mem[rchip];

endmodule

// File: rtl/codec_ctrl_wr.sv
module codec_ctrl_wr
    import codec_wr_pkg::*;
#(
    parameter int         NCHIP      = 2,
    parameter int         CLK_DIV    = 4,
    parameter int         RATE_W     = 18,
    parameter int         HIGH_ABOVE = 108000,
    parameter int         MID_ABOVE  = 54000,
    parameter logic [1:0] DEV_ADDR   = 2'b10,
    localparam int        CW         = (NCHIP > 1) ? $clog2(NCHIP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CW-1:0]     chip_idx,
    input  logic [4:0]        reg_addr,
    input  logic [7:0]        wr_data,
    input  logic              rate_start,
    input  logic [RATE_W-1:0] rate_hz,
    input  logic              mute_start,
    input  logic              mute_on,
    output logic              sclk,
    output logic              sdo,
    output logic [NCHIP-1:0]  cs_n,
    output logic              busy,
    output logic              done
);

    localparam int FRAME_W = 16;

    ctrl_state_t  state, state_nx;
    seq_op_t      op_q;
    logic [3:0]   mode_q;
    logic         mute_q;
    logic [CW-1:0] idx_q;
    logic         last_chip;

    logic               sh_go;
    logic [CW-1:0]      sh_chip;
    logic [FRAME_W-1:0] sh_frame;
    logic               fdone;

    logic        sw_we;
    logic [CW-1:0] sw_chip;
    logic [4:0]  sw_addr;
    logic [7:0]  sw_data;
    logic [7:0]  rd_speed;
    logic [7:0]  rd_mute;

    logic rate_ok;
    logic accept_direct, accept_rate, accept_mute;

    assign last_chip     = (idx_q == CW'(NCHIP - 1));
    assign rate_ok       = (rate_hz != '0);
    assign accept_direct = (state == T_IDLE) && start;
    assign accept_rate   = (state == T_IDLE) && !start && rate_start && rate_ok;
    assign accept_mute   = (state == T_IDLE) && !start && !(rate_start && rate_ok) && mute_start;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            T_IDLE: begin
                if (accept_direct)
                    state_nx = T_DIRECT;
                else if (accept_rate || accept_mute)
                    state_nx = T_SEQ_ISSUE;
            end
            T_DIRECT:    if (fdone) state_nx = T_IDLE;
            T_SEQ_ISSUE: state_nx = T_SEQ_WAIT;
            T_SEQ_WAIT:  if (fdone) state_nx = last_chip ? T_IDLE : T_SEQ_ISSUE;
            default:     state_nx = T_IDLE;
        endcase
    end

    // State register and request latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= T_IDLE;
            op_q   <= OP_SPEED;
            mode_q <= 4'h0;
            mute_q <= 1'b0;
            idx_q  <= '0;
        end else begin
            state <= state_nx;
            if (accept_rate) begin
                op_q   <= OP_SPEED;
                mode_q <= speed_mode(32'(rate_hz), 32'(HIGH_ABOVE), 32'(MID_ABOVE));
                idx_q  <= '0;
            end else if (accept_mute) begin
                op_q   <= OP_MUTE;
                mute_q <= mute_on;
                idx_q  <= '0;
            end else if ((state == T_SEQ_WAIT) && fdone && !last_chip) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Outputs and datapath controls
    always_comb begin
        sh_go    = 1'b0;
        sh_chip  = chip_idx;
        sh_frame = {DEV_ADDR, 1'b1, reg_addr, wr_data};
        sw_we    = 1'b0;
        sw_chip  = chip_idx;
        sw_addr  = reg_addr;
        sw_data  = wr_data;
        done     = 1'b0;
        unique case (state)
            T_IDLE: begin
                if (accept_direct) begin
                    sh_go = 1'b1;
                    sw_we = (reg_addr == SPEED_REG) || (reg_addr == MUTE_REG);
                end
            end
            T_SEQ_ISSUE: begin
                sh_go   = 1'b1;
                sh_chip = idx_q;
                sw_we   = 1'b1;
                sw_chip = idx_q;
                if (op_q == OP_SPEED) begin
                    sw_addr = SPEED_REG;
                    sw_data = {rd_speed[7:4], mode_q};
                end else begin
                    sw_addr = MUTE_REG;
                    sw_data = {mute_q, rd_mute[MUTE_BIT-1:0]};
                end
                sh_frame = {DEV_ADDR, 1'b1, sw_addr, sw_data};
            end
            T_DIRECT:   done = fdone;
            T_SEQ_WAIT: done = fdone && last_chip;
            default: ;
        endcase
    end

    assign busy = (state != T_IDLE);

    codec_shadow_regs #(.NCHIP(NCHIP)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (sw_we),
        .wchip    (sw_chip),
        .waddr    (sw_addr),
        .wdata    (sw_data),
        .rchip    (idx_q),
        .rd_speed (rd_speed),
        .rd_mute  (rd_mute)
    );

    codec_frame_shifter #(
        .NCHIP   (NCHIP),
        .CLK_DIV (CLK_DIV),
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (sh_go),
        .chip  (sh_chip),
        .frame (sh_frame),
        .sclk  (sclk),
        .sdo   (sdo),
        .cs_n  (cs_n),
        .fdone (fdone)
    );

    a_r4_idle_lines_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk && sdo && (&cs_n) && !done));

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_busy_drops_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r8_zero_rate_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rate_start && (rate_hz == '0) && !start && !mute_start) |=> !busy);

    a_r6_busy_keeps_select: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !(&cs_n)) |=> (cs_n == $past(cs_n)) || (&cs_n));

endmodule

// File: tb/codec_ctrl_wr_tb.sv
module codec_ctrl_wr_tb;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [0:0]  chip_idx = '0;
    logic [4:0]  reg_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rate_start = 1'b0;
    logic [17:0] rate_hz = '0;
    logic        mute_start = 1'b0;
    logic        mute_on = 1'b0;
    logic        sclk, sdo, busy, done;
    logic [1:0]  cs_n;

    int checks = 0;
    int errors = 0;
    int frames_seen = 0;
    int frames_exp = 0;
    logic [16:0] exp_q[$];
    logic [7:0]  m_speed [2] = '{8'h00, 8'h00};
    logic [7:0]  m_mute  [2] = '{8'h00, 8'h00};

    always #2.5 clk = ~clk;

    codec_ctrl_wr u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .chip_idx(chip_idx),
        .reg_addr(reg_addr), .wr_data(wr_data), .rate_start(rate_start),
        .rate_hz(rate_hz), .mute_start(mute_start), .mute_on(mute_on),
        .sclk(sclk), .sdo(sdo), .cs_n(cs_n), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [16:0] mk(input int chip, input logic [4:0] a, input logic [7:0] d);
        return {chip[0], 2'b10, 1'b1, a, d};
    endfunction

    task automatic push(input int chip, input logic [4:0] a, input logic [7:0] d);
        exp_q.push_back(mk(chip, a, d));
        frames_exp++;
        if (a == 5'h02) m_speed[chip] = d;
        if (a == 5'h03) m_mute[chip] = d;
    endtask

    task automatic wait_done(input string req);
        @(negedge clk);
        while (!done) @(negedge clk);
        check(cs_n == 2'b11 && sclk && sdo, req, {cs_n, sclk, sdo}, 4'hF);
        @(negedge clk);
        check(!busy, req, busy, 0);
    endtask

    task automatic do_write(input int chip, input logic [4:0] a, input logic [7:0] d);
        push(chip, a, d);
        @(negedge clk);
        chip_idx = chip[0]; reg_addr = a; wr_data = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy, "R5 busy after start", busy, 1);
        wait_done("R5 done with lines idle");
    endtask

    function automatic logic [3:0] bmode(input int r);
        if (r > 108000) return 4'b1010;
        if (r > 54000)  return 4'b0101;
        return 4'b0000;
    endfunction

    task automatic do_rate(input int r);
        for (int c = 0; c < 2; c++) push(c, 5'h02, {m_speed[c][7:4], bmode(r)});
        @(negedge clk);
        rate_hz = 18'(r); rate_start = 1'b1;
        @(negedge clk);
        rate_start = 1'b0;
        wait_done("R7 speed sequence done");
    endtask

    task automatic do_mute(input bit m);
        for (int c = 0; c < 2; c++) push(c, 5'h03, {m, m_mute[c][6:0]});
        @(negedge clk);
        mute_on = m; mute_start = 1'b1;
        @(negedge clk);
        mute_start = 1'b0;
        wait_done("R9 mute sequence done");
    endtask

    // Monitor: reassembles frames at the pins and compares with the scoreboard
    logic        prev_sclk = 1'b1;
    logic [1:0]  prev_cs = 2'b11;
    logic [15:0] bits;
    int          nbits, low_cnt, which;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_cs == 2'b11 && cs_n != 2'b11) begin
                bits = '0; nbits = 0; low_cnt = 0;
                which = cs_n[0] ? 1 : 0;
            end
            if (cs_n != 2'b11) begin
                low_cnt++;
                if (cs_n == 2'b00) check(0, "R3 both selects low", cs_n, 2'b10);
                if (!prev_sclk && sclk) begin
                    bits = {bits[14:0], sdo};
                    nbits++;
                end
            end
            if (prev_cs != 2'b11 && cs_n == 2'b11) begin
                frames_seen++;
                check(nbits == 16, "R1 bit count", nbits, 16);
                check(low_cnt == 50 * DIV, "R11 select low time", low_cnt, 50 * DIV);
                if (exp_q.size() == 0) begin
                    check(0, "R6 unexpected frame", {which[0], bits}, 0);
                end else begin
                    logic [16:0] e;
                    e = exp_q.pop_front();
                    check({which[0], bits} == e, "R1 R3 frame and select", {which[0], bits}, e);
                end
            end
            prev_cs = cs_n;
            prev_sclk = sclk;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(sclk && sdo && cs_n == 2'b11 && !busy && !done, "R4 reset levels",
              {sclk, sdo, cs_n, busy, done}, 6'b111100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        do_write(0, 5'h02, 8'hAA);               // R1, R10 shadow for codec 0
        do_write(1, 5'h11, 8'h3C);               // R3 codec 1 select
        do_rate(96000);                          // R7 mid rate, R10 shadow kept
        do_rate(192000);                         // R7 high rate
        do_rate(44100);                          // R7 normal rate

        // R8: zero rate produces nothing
        @(negedge clk);
        rate_hz = '0; rate_start = 1'b1;
        @(negedge clk);
        rate_start = 1'b0;
        check(!busy, "R8 zero rate busy", busy, 0);
        repeat (4) @(negedge clk);
        check(cs_n == 2'b11 && !busy, "R8 zero rate no frame", {cs_n, busy}, 3'b110);

        do_write(1, 5'h03, 8'h13);               // R10 mute shadow
        do_mute(1'b1);                           // R9 set
        do_mute(1'b0);                           // R9 clear

        // R6: requests during busy are ignored
        push(0, 5'h1F, 8'hFF);
        @(negedge clk);
        chip_idx = 1'b0; reg_addr = 5'h1F; wr_data = 8'hFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        chip_idx = 1'b1; reg_addr = 5'h05; wr_data = 8'h55; start = 1'b1;
        rate_hz = 18'd192000; rate_start = 1'b1; mute_on = 1'b1; mute_start = 1'b1;
        @(negedge clk);
        start = 1'b0; rate_start = 1'b0; mute_start = 1'b0;
        check(cs_n == 2'b10, "R6 select unchanged while busy", cs_n, 2'b10);
        wait_done("R6 done after ignored requests");
        repeat (3) @(negedge clk);
        check(!busy, "R6 no follow-up request", busy, 0);

        // R12: simultaneous requests, direct write wins
        push(1, 5'h0A, 8'h5A);
        @(negedge clk);
        chip_idx = 1'b1; reg_addr = 5'h0A; wr_data = 8'h5A; start = 1'b1;
        rate_hz = 18'd96000; rate_start = 1'b1; mute_start = 1'b1;
        @(negedge clk);
        start = 1'b0; rate_start = 1'b0; mute_start = 1'b0;
        wait_done("R12 priority done");
        repeat (3) @(negedge clk);
        check(!busy, "R12 losing requests dropped", busy, 0);

        // R9 shadow check via a speed write after mute (shadow of 0x02 untouched)
        do_rate(60000);                          // R7 R10

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R6 R8 scoreboard drained", exp_q.size(), 0);
        check(frames_seen == frames_exp, "R6 R8 frame count", frames_seen, frames_exp);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule